// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block is the target-side configuration register file of one bus function that uses the type-0 header layout. A host issues whole-dword configuration reads and writes, each naming a dword index within the 256-byte configuration space. The block answers with fixed identity values (vendor, device, revision, class and header type), keeps a small command word and an interrupt line byte, and holds six base address registers (BARs).

Each BAR is configured at build time as absent, a memory region or an I/O region, together with its size as a power of two. The low address bits below the region size and the type bits are hard-wired. Software can therefore write all ones to a BAR, read it back, clear the type bits and take the two's complement to learn the region length. It then writes the chosen base address. Any dword index that the block does not implement reads as zero.

Read data is registered. It changes on the clock edge that samples a read request and holds until the next one.

Top module: `cfgh_type0_hdr`

## Requirements
- R1: Dword index 0 (byte offset 0x00) reads the vendor ID in bits 15:0 and the device ID in bits 31:16.
- R2: Dword index 2 (0x08) reads the revision in bits 7:0 and the 24-bit class code in bits 31:8.
- R3: Dword index 3 (0x0C) reads the header type byte in bits 23:16. Bit 23 is the multi-function flag, bits 22:16 are 0, and all other bits are 0.
- R4: Dword index 1 (0x04) stores bits 15:0 of a write as the command word and reads it back in bits 15:0. Bits 31:16 read 0.
- R5: An implemented memory BAR of size 2^N reads bits 3:0 as 0 and bits N-1:0 as 0. After all ones are written, it reads ~(2^N - 1).
- R6: An implemented I/O BAR of size 2^N reads bit 0 as 1, bit 1 as 0 and bits N-1:2 as 0. After all ones are written, it reads ~(2^N - 1) | 1.
- R7: A write to an implemented BAR stores bits 31:N as its base, and a later read returns that base with its hard-wired low bits.
- R8: A BAR configured as absent reads 0, both before and after any write to it.
- R9: Dword index 15 (0x3C) stores bits 7:0 of a write as the interrupt line. Bits 31:8 read 0.
- R10: Writes to dword indices 0, 2 and 3 leave their read values unchanged.
- R11: A read of any dword index other than 0–9 and 15 returns 0.
- R12: After reset, the command word, the interrupt line, all BAR bases and the read data are 0.
- R13: Read data takes the addressed value on the rising edge where rd_en is high, and holds its value on every edge where rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_en | input | 1 | Read request for the dword at cfg_dword |
| wr_en | input | 1 | Write request for the dword at cfg_dword |
| cfg_dword | input | 6 | Dword index (byte offset divided by 4) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds the block with every BAR variant in play: BAR0 is a 4 KiB memory region, BAR1 a 32-byte I/O region, BAR2 a memory region at the 16-byte minimum, BAR3 absent, BAR4 an I/O region at the 4-byte minimum, and BAR5 a 1 MiB memory region. The multi-function flag is set, and the identity values are distinct and non-zero. With this build, both minimum-size edges of the hard-wired bit masks are reached, along with a wide mask, both type encodings and an absent slot. The multi-function bit of the header byte is visible as a 1, and the command word shows that status bits read as zero.

// File: rtl/cfgh_pkg.sv
package cfgh_pkg;
  localparam int BAR_COUNT = 6;
  localparam int DW_ID     = 0;
  localparam int DW_CMD    = 1;
  localparam int DW_CLASS  = 2;
  localparam int DW_HDR    = 3;
  localparam int DW_BAR0   = 4;
  localparam int DW_INTR   = 15;

  function automatic int bar_log2(input logic [5*BAR_COUNT-1:0] packed_log2, input int idx);
    return int'(packed_log2[5*idx +: 5]);
  endfunction
endpackage

// File: rtl/cfgh_bar_slot.sv
module cfgh_bar_slot #(
  parameter bit IS_IO     = 1'b0,
  parameter int SIZE_LOG2 = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_hit,
  input  logic [31-SIZE_LOG2:0] wr_base,
  output logic [31:0]           rd_val
);
  localparam int          BASE_W   = 32 - SIZE_LOG2;
  localparam logic [31:0] TYPE_LOW = IS_IO ? 32'h1 : 32'h0;

  logic [BASE_W-1:0] base_q, base_d;

  always_comb begin
    base_d = base_q;
    if (wr_hit) base_d = wr_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign rd_val = {base_q, {SIZE_LOG2{1'b0}}} | TYPE_LOW;
endmodule

// File: rtl/cfgh_read_mux.sv
module cfgh_read_mux
  import cfgh_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h0,
  parameter logic [15:0] DEVICE_ID  = 16'h0,
  parameter logic [23:0] CLASS_CODE = 24'h0,
  parameter logic [7:0]  REVISION   = 8'h0,
  parameter bit          MULTI_FUNC = 1'b0
) (
  input  logic [5:0]                 word,
  input  logic [15:0]                cmd,
  input  logic [7:0]                 intr_line,
  input  logic [BAR_COUNT-1:0][31:0] bar_rd,
  output logic [31:0]                data
);
  always_comb begin
    data = 32'h0;
    case (int'(word))
      DW_ID:    data = {DEVICE_ID, VENDOR_ID};
      DW_CMD:   data = {16'h0, cmd};
      DW_CLASS: data = {CLASS_CODE, REVISION};
      DW_HDR:   data = {8'h0, MULTI_FUNC, 7'h0, 16'h0};
      DW_INTR:  data = {24'h0, intr_line};
      default: begin
        if (word >= 6'(DW_BAR0) && word < 6'(DW_BAR0 + BAR_COUNT))
          data = bar_rd[word - 6'(DW_BAR0)];
      end
    endcase
  end
endmodule

// File: rtl/cfgh_type0_hdr.sv
module cfgh_type0_hdr
  import cfgh_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1234,
  parameter logic [15:0] DEVICE_ID  = 16'h5678,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter logic [7:0]  REVISION   = 8'h01,
  parameter bit          MULTI_FUNC = 1'b0,
  parameter logic [5:0]  BAR_EN     = 6'b000011,
  parameter logic [5:0]  BAR_IO     = 6'b000010,
  parameter logic [29:0] BAR_LOG2   = {5'd0, 5'd0, 5'd0, 5'd0, 5'd8, 5'd12}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [5:0]  cfg_dword,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  logic [15:0]                cmd_q, cmd_d;
  logic [7:0]                 intr_q, intr_d;
  logic [31:0]                rd_q, rd_d, mux_val;
  logic [BAR_COUNT-1:0][31:0] bar_rd;

  for (genvar i = 0; i < BAR_COUNT; i++) begin : g_bar
    if (BAR_EN[i]) begin : g_on
      localparam int LG = bar_log2(BAR_LOG2, i);
      logic hit;
      assign hit = wr_en && (cfg_dword == 6'(DW_BAR0 + i));
      cfgh_bar_slot #(.IS_IO(BAR_IO[i]), .SIZE_LOG2(LG)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (hit),
        .wr_base(wr_data[31:LG]),
        .rd_val (bar_rd[i])
      );
    end else begin : g_off
      assign bar_rd[i] = 32'h0;
    end
  end

  cfgh_read_mux #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .CLASS_CODE(CLASS_CODE),
    .REVISION  (REVISION),
    .MULTI_FUNC(MULTI_FUNC)
  ) u_mux (
    .word     (cfg_dword),
    .cmd      (cmd_q),
    .intr_line(intr_q),
    .bar_rd   (bar_rd),
    .data     (mux_val)
  );

  always_comb begin
    cmd_d  = cmd_q;
    intr_d = intr_q;
    rd_d   = rd_q;
    if (wr_en && cfg_dword == 6'(DW_CMD))  cmd_d  = wr_data[15:0];
    if (wr_en && cfg_dword == 6'(DW_INTR)) intr_d = wr_data[7:0];
    if (rd_en) rd_d = mux_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      intr_q <= '0;
      rd_q   <= '0;
    end else begin
      cmd_q  <= cmd_d;
      intr_q <= intr_d;
      rd_q   <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/cfgh_type0_hdr_chk.sv
module cfgh_type0_hdr_chk
  import cfgh_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h0,
  parameter logic [15:0] DEVICE_ID  = 16'h0,
  parameter logic [23:0] CLASS_CODE = 24'h0,
  parameter logic [7:0]  REVISION   = 8'h0,
  parameter bit          MULTI_FUNC = 1'b0,
  parameter logic [5:0]  BAR_EN     = 6'b0,
  parameter logic [5:0]  BAR_IO     = 6'b0,
  parameter logic [29:0] BAR_LOG2   = 30'h0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [5:0]  cfg_dword,
  input logic [31:0] rd_data
);
  logic unused_hole;
  assign unused_hole = (cfg_dword > 6'd9) && (cfg_dword != 6'd15);

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && cfg_dword == 6'd0 |=> rd_data == {DEVICE_ID, VENDOR_ID}); // R1
  AST_CLASS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && cfg_dword == 6'd2 |=> rd_data == {CLASS_CODE, REVISION}); // R2
  AST_HDR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && cfg_dword == 6'd3 |=> rd_data == {8'h0, MULTI_FUNC, 23'h0}); // R3
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && cfg_dword == 6'd1 |=> rd_data[31:16] == 16'h0); // R4
  AST_INTR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && cfg_dword == 6'd15 |=> rd_data[31:8] == 24'h0); // R9
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && unused_hole |=> rd_data == 32'h0); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R13

  for (genvar i = 0; i < BAR_COUNT; i++) begin : g_chk
    if (BAR_EN[i]) begin : g_on
      localparam int          LG   = bar_log2(BAR_LOG2, i);
      localparam logic [31:0] LOWM = (32'h1 << LG) - 32'h1;
      localparam logic [31:0] TYP  = BAR_IO[i] ? 32'h1 : 32'h0;
      AST_BAR_LOWBITS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && cfg_dword == 6'(DW_BAR0 + i) |=> (rd_data & LOWM) == TYP); // R5 R6
    end else begin : g_off
      AST_BAR_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && cfg_dword == 6'(DW_BAR0 + i) |=> rd_data == 32'h0); // R8
    end
  end
endmodule

bind cfgh_type0_hdr cfgh_type0_hdr_chk #(
  .VENDOR_ID (VENDOR_ID),
  .DEVICE_ID (DEVICE_ID),
  .CLASS_CODE(CLASS_CODE),
  .REVISION  (REVISION),
  .MULTI_FUNC(MULTI_FUNC),
  .BAR_EN    (BAR_EN),
  .BAR_IO    (BAR_IO),
  .BAR_LOG2  (BAR_LOG2)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .cfg_dword(cfg_dword),
  .rd_data  (rd_data)
);

// File: tb/sim_cfgh_type0_hdr.sv
`timescale 1ns/1ps
module sim_cfgh_type0_hdr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, wr_en;
  logic [5:0]  cfg_dword;
  logic [31:0] wr_data;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cfgh_type0_hdr #(
    .VENDOR_ID (16'h1a2b),
    .DEVICE_ID (16'h3c4d),
    .CLASS_CODE(24'h020000),
    .REVISION  (8'h07),
    .MULTI_FUNC(1'b1),
    .BAR_EN    (6'b110111),
    .BAR_IO    (6'b010010),
    .BAR_LOG2  ({5'd20, 5'd2, 5'd0, 5'd4, 5'd5, 5'd12})
  ) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .cfg_dword(cfg_dword), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input int off, input logic [31:0] d);
    @(negedge clk);
    cfg_dword = 6'(off >> 2); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg_rd(input int off, output logic [31:0] d);
    @(negedge clk);
    cfg_dword = 6'(off >> 2); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R12 rd_data after reset", rd_data, 32'h0);
    cfg_rd(32'h04, v); check("R12 command after reset", v, 32'h0);
    cfg_rd(32'h3C, v); check("R12 intr after reset", v, 32'h0);
    cfg_rd(32'h10, v); check("R12 BAR0 after reset", v, 32'h0);
    cfg_rd(32'h14, v); check("R12 BAR1 after reset", v, 32'h1);
  endtask

  task automatic t_identity;
    logic [31:0] v;
    cfg_rd(32'h00, v); check("R1 id", v, 32'h3c4d1a2b);
    cfg_rd(32'h08, v); check("R2 class/rev", v, 32'h02000007);
    cfg_rd(32'h0C, v); check("R3 header type", v, 32'h00800000);
    cfg_wr(32'h00, 32'hFFFFFFFF);
    cfg_wr(32'h08, 32'h0);
    cfg_wr(32'h0C, 32'hFFFFFFFF);
    cfg_rd(32'h00, v); check("R10 id after write", v, 32'h3c4d1a2b);
    cfg_rd(32'h08, v); check("R10 class after write", v, 32'h02000007);
    cfg_rd(32'h0C, v); check("R10 header after write", v, 32'h00800000);
  endtask

  task automatic t_command;
    logic [31:0] v;
    cfg_wr(32'h04, 32'hABCD1234);
    cfg_rd(32'h04, v); check("R4 command store", v, 32'h00001234);
  endtask

  task automatic t_bar_size;
    logic [31:0] v;
    cfg_wr(32'h10, 32'hFFFFFFFF); cfg_rd(32'h10, v);
    check("R5 BAR0 mask", v, 32'hFFFFF000);
    check("R5 BAR0 length", ~(v & ~32'hF) + 32'h1, 32'h1000);
    cfg_wr(32'h18, 32'hFFFFFFFF); cfg_rd(32'h18, v);
    check("R5 BAR2 min mask", v, 32'hFFFFFFF0);
    cfg_wr(32'h24, 32'hFFFFFFFF); cfg_rd(32'h24, v);
    check("R5 BAR5 mask", v, 32'hFFF00000);
    cfg_wr(32'h14, 32'hFFFFFFFF); cfg_rd(32'h14, v);
    check("R6 BAR1 mask", v, 32'hFFFFFFE1);
    check("R6 BAR1 length", ~(v & ~32'h3) + 32'h1, 32'h20);
    cfg_wr(32'h20, 32'hFFFFFFFF); cfg_rd(32'h20, v);
    check("R6 BAR4 min mask", v, 32'hFFFFFFFD);
    cfg_wr(32'h10, 32'h12345678); cfg_rd(32'h10, v);
    check("R7 BAR0 base", v, 32'h12345000);
    cfg_wr(32'h14, 32'h0000C0A3); cfg_rd(32'h14, v);
    check("R7 BAR1 base", v, 32'h0000C0A1);
    cfg_wr(32'h24, 32'hFEDCBA98); cfg_rd(32'h24, v);
    check("R7 BAR5 base", v, 32'hFED00000);
  endtask

  task automatic t_bar_off;
    logic [31:0] v;
    cfg_rd(32'h1C, v); check("R8 BAR3 absent", v, 32'h0);
    cfg_wr(32'h1C, 32'hFFFFFFFF);
    cfg_rd(32'h1C, v); check("R8 BAR3 after write", v, 32'h0);
  endtask

  task automatic t_intr;
    logic [31:0] v;
    cfg_wr(32'h3C, 32'hFFFFFF0B);
    cfg_rd(32'h3C, v); check("R9 intr line", v, 32'h0000000B);
  endtask

  task automatic t_holes;
    logic [31:0] v;
    int offs[7] = '{32'h28, 32'h2C, 32'h30, 32'h34, 32'h38, 32'h40, 32'hFC};
    foreach (offs[k]) begin
      cfg_wr(offs[k], 32'hFFFFFFFF);
      cfg_rd(offs[k], v);
      check("R11 hole reads zero", v, 32'h0);
    end
  endtask

  task automatic t_hold;
    logic [31:0] v;
    cfg_rd(32'h00, v);
    check("R13 read capture", v, 32'h3c4d1a2b);
    @(negedge clk); cfg_dword = 6'd2;
    repeat (3) @(negedge clk);
    check("R13 hold without rd_en", rd_data, 32'h3c4d1a2b);
  endtask

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; cfg_dword = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_command();
    t_bar_size();
    t_bar_off();
    t_intr();
    t_holes();
    t_hold();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule